// File: doc/BRIEF.md
# Display RAM address generator

This block keeps the column (X) and row (Y) pointers that a host uses when it reads or writes a graphics display memory. The host loads either pointer, or a small mode register, through a byte-wide write port. The mode register sets the word length, 6 or 8 bits, and picks which pointer advances. Each access strobe from the host then steps the chosen pointer by one, so the host can stream data without reloading addresses.

The word length sets the largest legal X value. A pointer write that would land outside its legal range is dropped, and the old value stays. When a stepping pointer passes its top value it wraps to zero. When the host shortens the legal X range while X is beyond it, X is cleared. A one-cycle pulse reports each step, in the cycle when the new address appears.

Top module: `dram_addr_gen`

## Requirements
- R1: After reset, x_addr and y_addr are 0, the mode is 8-bit words with Y stepping, and adv is low.
- R2: wr_sel selects the target of a write: 2'b00 mode register, 2'b01 X, 2'b10 Y. In the mode register, bit 1 set means 6-bit words and bit 0 set means X steps; the other bits are ignored.
- R3: An X write with wr_data at most 0x27 (8-bit words) or at most 0x35 (6-bit words) loads X on the next edge; a larger value leaves X unchanged.
- R4: A Y write with wr_data at most 0x40 loads Y; a larger value leaves Y unchanged.
- R5: With Y stepping, acc_stb with wr_en low raises Y by one and leaves X unchanged.
- R6: With X stepping, acc_stb with wr_en low raises X by one and leaves Y unchanged.
- R7: A step from the top legal value (X limit from R3, Y limit 0x40) wraps that pointer to 0; the other pointer does not change.
- R8: A mode write that selects a word length whose X limit is below the current X clears X to 0; otherwise X is kept.
- R9: When wr_en and acc_stb are high in the same cycle, the write takes effect and no step happens.
- R10: adv is high for exactly the cycle after each step that took place, and low otherwise.
- R11: A write with wr_sel 2'b11 changes neither pointer nor the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data |
| acc_stb | input | 1 | Host display memory access strobe |
| x_addr | output | 6 | Current X pointer |
| y_addr | output | 7 | Current Y pointer |
| adv | output | 1 | Pulse: a pointer stepped on the last edge |

## Verification
The assertions assume every input is a known 0 or 1 at each rising edge once reset is released, and that wr_sel and wr_data carry meaning only while wr_en is high. The bench drives all inputs on the falling edge from one task, never leaves them unknown, and mixes directed sequences around each limit with a long pseudo-random run in which out-of-range data, unused selects and colliding strobes all appear.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int DATA_W = 8;
  localparam int X_W    = 6;
  localparam int Y_W    = 7;

  localparam logic [1:0] SEL_MODE = 2'b00;
  localparam logic [1:0] SEL_X    = 2'b01;
  localparam logic [1:0] SEL_Y    = 2'b10;

  localparam int BIT_STEP_X = 0;
  localparam int BIT_WORD6  = 1;

  localparam logic [X_W-1:0] X_TOP_W8 = 6'h27;
  localparam logic [X_W-1:0] X_TOP_W6 = 6'h35;
  localparam logic [Y_W-1:0] Y_TOP    = 7'h40;

  function automatic logic [X_W-1:0] x_top(input logic word6);
    return word6 ? X_TOP_W6 : X_TOP_W8;
  endfunction

  function automatic logic fits(input logic [DATA_W-1:0] v, input logic [DATA_W-1:0] top);
    return v <= top;
  endfunction
endpackage

// File: rtl/dag_mode_reg.sv
module dag_mode_reg
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic              word6,
  output logic              step_x
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word6  <= 1'b0;
      step_x <= 1'b0;
    end else if (ld) begin
      word6  <= ld_data[BIT_WORD6];
      step_x <= ld_data[BIT_STEP_X];
    end
  end
endmodule

// File: rtl/dag_axis.sv
module dag_axis
  import dag_pkg::*;
#(
  parameter int W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [W-1:0]      top,
  input  logic              inc,
  input  logic              clr,
  output logic [W-1:0]      val,
  output logic              ld_ok,
  output logic              wrap
);
  localparam int PAD = DATA_W - W;

  assign ld_ok = ld && fits(ld_data, {{PAD{1'b0}}, top});
  assign wrap  = inc && (val == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (ld) begin
      if (ld_ok) val <= ld_data[W-1:0];
    end else if (clr) begin
      val <= '0;
    end else if (inc) begin
      val <= wrap ? '0 : val + 1'b1;
    end
  end
endmodule

// File: rtl/dram_addr_gen.sv
module dram_addr_gen
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              acc_stb,
  output logic [X_W-1:0]    x_addr,
  output logic [Y_W-1:0]    y_addr,
  output logic              adv
);
  logic mode_word6, mode_step_x;
  logic mode_wr, x_wr, y_wr;
  logic step_go, x_inc, y_inc, x_clr;
  logic x_ld_ok, y_ld_ok, x_wrap, y_wrap;
  logic [X_W-1:0] x_top_now;

  assign mode_wr   = wr_en && (wr_sel == SEL_MODE);
  assign x_wr      = wr_en && (wr_sel == SEL_X);
  assign y_wr      = wr_en && (wr_sel == SEL_Y);
  assign step_go   = acc_stb && !wr_en;
  assign x_inc     = step_go && mode_step_x;
  assign y_inc     = step_go && !mode_step_x;
  assign x_top_now = x_top(mode_word6);
  assign x_clr     = mode_wr && (x_addr > x_top(wr_data[BIT_WORD6]));

  dag_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .ld(mode_wr), .ld_data(wr_data),
    .word6(mode_word6), .step_x(mode_step_x)
  );

  dag_axis #(.W(X_W)) u_x (
    .clk(clk), .rst_n(rst_n), .ld(x_wr), .ld_data(wr_data),
    .top(x_top_now), .inc(x_inc), .clr(x_clr),
    .val(x_addr), .ld_ok(x_ld_ok), .wrap(x_wrap)
  );

  dag_axis #(.W(Y_W)) u_y (
    .clk(clk), .rst_n(rst_n), .ld(y_wr), .ld_data(wr_data),
    .top(Y_TOP), .inc(y_inc), .clr(1'b0),
    .val(y_addr), .ld_ok(y_ld_ok), .wrap(y_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv <= 1'b0;
    else        adv <= step_go;
  end
endmodule

// File: rtl/dag_checker.sv
module dag_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       acc_stb,
  input logic [5:0] x_addr,
  input logic [6:0] y_addr,
  input logic       adv,
  input logic       word6,
  input logic       x_wrap,
  input logic       y_wrap
);
  AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    x_addr <= (word6 ? 6'h35 : 6'h27)); // R3
  AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    y_addr <= 7'h40); // R4
  AST_BAD_X_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b01 && wr_data > (word6 ? 8'h35 : 8'h27)) |=> $stable(x_addr)); // R3
  AST_BAD_Y_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b10 && wr_data > 8'h40) |=> $stable(y_addr)); // R4
  AST_ONE_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !wr_en) |=> ($stable(x_addr) || $stable(y_addr))); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (x_wrap || y_wrap) |=> (x_addr == 6'd0 || y_addr == 7'd0)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_stb) |=> !adv); // R9
  AST_ADV_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !wr_en) |=> adv); // R10
  AST_NO_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> !adv); // R10
  AST_SEL3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b11) |=> ($stable(x_addr) && $stable(y_addr))); // R11
endmodule

bind dram_addr_gen dag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .acc_stb(acc_stb), .x_addr(x_addr), .y_addr(y_addr), .adv(adv),
  .word6(mode_word6), .x_wrap(x_wrap), .y_wrap(y_wrap)
);

// File: tb/sim_dram_addr_gen.sv
module sim_dram_addr_gen;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic       acc_stb = 1'b0;
  logic [5:0] x_addr;
  logic [6:0] y_addr;
  logic       adv;

  int errors = 0;
  int checks = 0;

  // reference state
  int m_x = 0, m_y = 0, m_w6 = 0, m_sx = 0, m_adv = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .acc_stb(acc_stb), .x_addr(x_addr), .y_addr(y_addr), .adv(adv)
  );

  function automatic int xlim(int w6);
    return (w6 != 0) ? 39 + 14 : 39;
  endfunction

  task automatic model_edge();
    int d = wr_data;
    if (wr_en) begin
      m_adv = 0;
      case (wr_sel)
        2'b00: begin
          m_w6 = d / 2 % 2;
          m_sx = d % 2;
          if (m_x > xlim(m_w6)) m_x = 0;
        end
        2'b01: if (d <= xlim(m_w6)) m_x = d;
        2'b10: if (d <= 64) m_y = d;
        default: ;
      endcase
    end else if (acc_stb) begin
      m_adv = 1;
      if (m_sx != 0) m_x = (m_x >= xlim(m_w6)) ? 0 : m_x + 1;
      else           m_y = (m_y >= 64) ? 0 : m_y + 1;
    end else begin
      m_adv = 0;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (x_addr !== 6'(m_x) || y_addr !== 7'(m_y) || adv !== 1'(m_adv)) begin
      errors++;
      $display("FAIL %s: got x=%0h y=%0h adv=%0b, expected x=%0h y=%0h adv=%0d",
               tag, x_addr, y_addr, adv, m_x, m_y, m_adv);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d,
                     input logic acc, input string tag);
    wr_en = we; wr_sel = sel; wr_data = d; acc_stb = acc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    // R5: Y steps by default
    for (int i = 0; i < 3; i++) cyc(0, 2'b00, 8'h00, 1, "R5");
    cyc(0, 2'b00, 8'h00, 0, "R10");
    // R4 / R7 on Y
    cyc(1, 2'b10, 8'h3e, 0, "R4");
    for (int i = 0; i < 4; i++) cyc(0, 2'b00, 8'h00, 1, "R7");
    cyc(1, 2'b10, 8'h41, 0, "R4");
    cyc(1, 2'b10, 8'h80, 0, "R4");
    cyc(1, 2'b10, 8'h40, 0, "R4");
    // R2 / R6: X steps
    cyc(1, 2'b00, 8'h01, 0, "R2");
    cyc(0, 2'b00, 8'h00, 1, "R6");
    cyc(1, 2'b01, 8'h27, 0, "R3");
    cyc(0, 2'b00, 8'h00, 1, "R7");
    cyc(1, 2'b01, 8'h28, 0, "R3");
    cyc(1, 2'b01, 8'hc0, 0, "R3");
    // 6-bit words
    cyc(1, 2'b00, 8'hfb, 0, "R2");
    cyc(1, 2'b01, 8'h35, 0, "R3");
    cyc(0, 2'b00, 8'h00, 1, "R7");
    cyc(1, 2'b01, 8'h36, 0, "R3");
    cyc(1, 2'b01, 8'h30, 0, "R3");
    cyc(1, 2'b00, 8'h01, 0, "R8");
    cyc(1, 2'b00, 8'h03, 0, "R8");
    cyc(1, 2'b01, 8'h20, 0, "R3");
    cyc(1, 2'b00, 8'h01, 0, "R8");
    // R9: write beats access
    cyc(1, 2'b01, 8'h05, 1, "R9");
    cyc(1, 2'b10, 8'h11, 1, "R9");
    // R11: unused select
    cyc(1, 2'b11, 8'h00, 0, "R11");
    cyc(1, 2'b11, 8'h3f, 1, "R11");
    cyc(0, 2'b00, 8'h00, 1, "R6");
    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc(($urandom % 4) == 0, 2'($urandom), r, ($urandom % 3) != 0, "R10");
    end
    // reset again mid-run
    rst_n = 1'b0;
    m_x = 0; m_y = 0; m_w6 = 0; m_sx = 0; m_adv = 0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    cyc(0, 2'b00, 8'h00, 1, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule